// File: doc/BRIEF.md
# VBUS monitor and power path controller

This block watches a digitized VBUS reading on the source side of a USB Type-C port and decides when the outgoing power switch may be closed. It compares each sample against a window around the target voltage code. The upper and lower margins are set separately. When the range check is turned off, the block compares the sample against a single undervoltage code instead. The block drives an active-low power-path enable, which stands for an open-drain output: a low level closes the switch and a high level releases it.

Before the path first closes, the optional VDD undervoltage and overvoltage flags must pass. Once the path is closed, only the VBUS result matters. A change of target code opens a blanking interval during which VBUS faults are ignored. If the new target is lower than the old one, the discharge path is switched on for that interval. Discharge is also run for a programmable time after detach or when a fault forces error recovery. A millisecond tick paces both intervals.

Top module: `vbus_path_ctrl`

## Requirements
- R1: After reset, `path_en_n` is 1, `dischg_on` is 0, `err_req` is 0 and `vbus_ok` is 0.
- R2: Thresholds are held in registers. The upper threshold is floor(T*(105+h)/100) and the lower threshold is floor(T*(95-l)/100), where T is `target_code`, h is `hi_trim` and l is `lo_trim`. A trim of 5 therefore gives a margin of 10%. Both limits count as inside the window.
- R3: With `range_chk_en`=1, a sample is valid when lower <= `vbus_code` <= upper. With `range_chk_en`=0, a sample is valid when `vbus_code` > `vbus_uvlo_code`.
- R4: One valid in-range sample sets `vbus_ok`. Only two consecutive out-of-range samples clear it, counting only cycles where `sample_valid`=1. When `conn_state` is 0 (unattached), `vbus_ok` is cleared.
- R5: `path_en_n` goes low one clock after a cycle in which all of these hold:
  - `conn_state` is 1, 2 or 3 (attached as source, or either debug accessory state);
  - `vbus_ok`=1;
  - no blanking and no target change in that cycle;
  - VDD is good, meaning neither (`vdd_uv_chk` and `vdd_uv_flag`) nor (`vdd_ov_chk` and `vdd_ov_flag`) holds.
- R6: Once `path_en_n` is low, the VDD flags have no effect on it.
- R7: When `conn_state` returns to 0 while the path is closed, `path_en_n` rises on the next clock. If `dischg_en`=1, `dischg_on` then stays high for `dischg_ms` ticks.
- R8: When `vbus_ok` is 0 while the path is closed and the port is attached, the block does three things on the next clock: it releases the path, raises `err_req`, and starts the timed discharge. `err_req` stays high until `conn_state` is 0.
- R9: A change of `target_code` blanks monitoring for `xition_ms` ticks. The change cycle itself is also blanked. While blanked, `vbus_ok` holds and the path cannot first close.
- R10: If the new target is lower than the previous one and `dischg_en`=1, `dischg_on` is high while blanking is active.
- R11: With `dischg_en`=0, neither detach, fault nor a lower target raises `dischg_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| conn_state | input | 2 | 0 unattached, 1 attached source, 2 unoriented debug, 3 oriented debug |
| vdd_uv_flag | input | 1 | VDD below undervoltage limit |
| vdd_ov_flag | input | 1 | VDD above overvoltage limit |
| vdd_uv_chk | input | 1 | Enable VDD undervoltage qualification |
| vdd_ov_chk | input | 1 | Enable VDD overvoltage qualification |
| sample_valid | input | 1 | `vbus_code` holds a new sample |
| vbus_code | input | CODE_W | Digitized VBUS |
| target_code | input | CODE_W | Nominal VBUS code |
| hi_trim | input | TRIM_W | Extra upper margin, percent |
| lo_trim | input | TRIM_W | Extra lower margin, percent |
| range_chk_en | input | 1 | 1 window check, 0 undervoltage-only check |
| vbus_uvlo_code | input | CODE_W | Undervoltage code for the window-off mode |
| dischg_en | input | 1 | Allow the discharge path |
| xition_ms | input | MS_W | Blanking time in ticks |
| dischg_ms | input | MS_W | Discharge time in ticks |
| path_en_n | output | 1 | Power path enable, low closes the switch |
| dischg_on | output | 1 | Discharge path on |
| err_req | output | 1 | Error recovery request |
| vbus_ok | output | 1 | Filtered VBUS validity |
| blanking | output | 1 | Monitoring masked after a target change |

## Verification
Every output comes from a register, so the result of an input change shows one clock edge later. The exception is `vbus_ok`, which follows a change in `vbus_code` one edge later for an in-range sample and two valid edges later for an out-of-range one. The path state then follows `vbus_ok` one edge after that. Interval outputs fall after the stated number of ticks, counted from the edge that loaded them. The bench drives inputs just after the falling edge and advances a behavioural model on each rising edge. It compares all four outputs at the following falling edge, so each result is sampled in the cycle it is due. Directed checks are placed several cycles after each stimulus to confirm the settled value.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
  typedef enum logic [1:0] {PP_OFF = 2'd0, PP_ON = 2'd1, PP_RECOV = 2'd2} pp_state_e;

  localparam logic [1:0] CONN_IDLE = 2'd0;

  function automatic int unsigned upper_limit(int unsigned tgt, int unsigned trim);
    return (tgt * (105 + trim)) / 100;
  endfunction

  function automatic int unsigned lower_limit(int unsigned tgt, int unsigned trim);
    return (tgt * (95 - trim)) / 100;
  endfunction
endpackage

// File: rtl/ms_down_counter.sv
module ms_down_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/vbus_window.sv
module vbus_window import vbus_pkg::*; #(
  parameter int CODE_W = 10,
  parameter int TRIM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] target_code,
  input  logic [TRIM_W-1:0] hi_trim,
  input  logic [TRIM_W-1:0] lo_trim,
  input  logic              range_chk_en,
  input  logic [CODE_W-1:0] vbus_uvlo_code,
  input  logic [CODE_W-1:0] vbus_code,
  output logic              in_range
);
  localparam int THR_W = CODE_W + 1;

  logic [THR_W-1:0] thr_hi, thr_lo;
  logic [THR_W-1:0] code_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_hi <= '0;
      thr_lo <= '0;
    end else begin
      thr_hi <= THR_W'(upper_limit(32'(target_code), 32'(hi_trim)));
      thr_lo <= THR_W'(lower_limit(32'(target_code), 32'(lo_trim)));
    end
  end

  assign code_x = {1'b0, vbus_code};

  always_comb begin
    if (range_chk_en) in_range = (code_x >= thr_lo) && (code_x <= thr_hi);
    else              in_range = (vbus_code > vbus_uvlo_code);
  end
endmodule

// File: rtl/vbus_filter.sv
module vbus_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic upd,
  input  logic in_range,
  output logic ok,
  output logic bad_one
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok      <= 1'b0;
      bad_one <= 1'b0;
    end else if (clear) begin
      ok      <= 1'b0;
      bad_one <= 1'b0;
    end else if (upd) begin
      if (in_range) begin
        ok      <= 1'b1;
        bad_one <= 1'b0;
      end else begin
        if (bad_one) ok <= 1'b0;
        bad_one <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vbus_path_ctrl.sv
module vbus_path_ctrl import vbus_pkg::*; #(
  parameter int CODE_W = 10,
  parameter int TRIM_W = 4,
  parameter int MS_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic [1:0]        conn_state,
  input  logic              vdd_uv_flag,
  input  logic              vdd_ov_flag,
  input  logic              vdd_uv_chk,
  input  logic              vdd_ov_chk,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] vbus_code,
  input  logic [CODE_W-1:0] target_code,
  input  logic [TRIM_W-1:0] hi_trim,
  input  logic [TRIM_W-1:0] lo_trim,
  input  logic              range_chk_en,
  input  logic [CODE_W-1:0] vbus_uvlo_code,
  input  logic              dischg_en,
  input  logic [MS_W-1:0]   xition_ms,
  input  logic [MS_W-1:0]   dischg_ms,
  output logic              path_en_n,
  output logic              dischg_on,
  output logic              err_req,
  output logic              vbus_ok,
  output logic              blanking
);
  logic [CODE_W-1:0] target_q;
  logic              tgt_chg, blank_low;
  logic              in_range, bad_one;
  logic              attached, vdd_good, filt_upd;
  logic              dis_load, dis_busy;
  pp_state_e         state, state_nx;

  assign attached = (conn_state != CONN_IDLE);
  assign vdd_good = !(vdd_uv_chk && vdd_uv_flag) && !(vdd_ov_chk && vdd_ov_flag);
  assign tgt_chg  = (target_code != target_q);
  assign filt_upd = sample_valid && !blanking && !tgt_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q  <= '0;
      blank_low <= 1'b0;
    end else begin
      target_q <= target_code;
      if (tgt_chg) blank_low <= dischg_en && (target_code < target_q);
    end
  end

  vbus_window #(.CODE_W(CODE_W), .TRIM_W(TRIM_W)) u_window (
    .clk(clk), .rst_n(rst_n), .target_code(target_code), .hi_trim(hi_trim),
    .lo_trim(lo_trim), .range_chk_en(range_chk_en), .vbus_uvlo_code(vbus_uvlo_code),
    .vbus_code(vbus_code), .in_range(in_range)
  );

  vbus_filter u_filter (
    .clk(clk), .rst_n(rst_n), .clear(!attached), .upd(filt_upd),
    .in_range(in_range), .ok(vbus_ok), .bad_one(bad_one)
  );

  ms_down_counter #(.W(MS_W)) u_blank (
    .clk(clk), .rst_n(rst_n), .load(tgt_chg), .load_val(xition_ms),
    .tick(ms_tick), .busy(blanking)
  );

  ms_down_counter #(.W(MS_W)) u_dis (
    .clk(clk), .rst_n(rst_n), .load(dis_load && dischg_en), .load_val(dischg_ms),
    .tick(ms_tick), .busy(dis_busy)
  );

  assign dis_load = (state == PP_ON) && (!attached || !vbus_ok);

  always_comb begin
    state_nx = state;
    unique case (state)
      PP_OFF:   if (attached && vdd_good && vbus_ok && !blanking && !tgt_chg) state_nx = PP_ON;
      PP_ON:    if (!attached) state_nx = PP_OFF;
                else if (!vbus_ok) state_nx = PP_RECOV;
      PP_RECOV: if (!attached) state_nx = PP_OFF;
      default:  state_nx = PP_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PP_OFF;
    else        state <= state_nx;
  end

  assign path_en_n = (state != PP_ON);
  assign err_req   = (state == PP_RECOV);
  assign dischg_on = dis_busy || (blanking && blank_low);
endmodule

// File: rtl/vbus_path_chk.sv
module vbus_path_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] conn_state,
  input logic       path_en_n,
  input logic       err_req,
  input logic       vbus_ok,
  input logic       bad_one,
  input logic       blanking,
  input logic       vdd_good
);
  // R5: closing the path needs attach, good VBUS, good VDD and no blanking
  p_enable_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(path_en_n) |-> ($past(conn_state) != 2'd0 && $past(vbus_ok) &&
                          $past(vdd_good) && !$past(blanking)));

  // R6: with the path closed and VBUS good, nothing else opens it while attached
  p_vdd_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!path_en_n && conn_state != 2'd0 && vbus_ok) |=> !path_en_n);

  // R7: detach releases the path on the next clock
  p_detach_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!path_en_n && conn_state == 2'd0) |=> path_en_n);

  // R8: fault while closed leads to release plus error request
  p_fault_recovery_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!path_en_n && conn_state != 2'd0 && !vbus_ok) |=> (path_en_n && err_req));

  // R8: error request never coexists with a closed path
  p_err_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> path_en_n);

  // R4: validity falls only after a prior strike or on detach
  p_two_strikes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vbus_ok) |-> ($past(conn_state) == 2'd0 || $past(bad_one)));

  // R9: validity is frozen while blanking
  p_blank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (blanking && conn_state != 2'd0) |=> $stable(vbus_ok));
endmodule

bind vbus_path_ctrl vbus_path_chk i_chk (
  .clk(clk), .rst_n(rst_n), .conn_state(conn_state), .path_en_n(path_en_n),
  .err_req(err_req), .vbus_ok(vbus_ok), .bad_one(bad_one),
  .blanking(blanking), .vdd_good(vdd_good)
);

// File: tb/test_vbus_path_ctrl.sv
`timescale 1ns/100ps
module test_vbus_path_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic [1:0] conn_state = 2'd0;
  logic       vdd_uv_flag = 1'b0, vdd_ov_flag = 1'b0, vdd_uv_chk = 1'b0, vdd_ov_chk = 1'b0;
  logic       sample_valid = 1'b0;
  logic [9:0] vbus_code = '0, target_code = '0, vbus_uvlo_code = 10'd200;
  logic [3:0] hi_trim = 4'd5, lo_trim = 4'd5;
  logic       range_chk_en = 1'b1, dischg_en = 1'b1;
  logic [8:0] xition_ms = 9'd3, dischg_ms = 9'd4;
  logic       path_en_n, dischg_on, err_req, vbus_ok, blanking;

  int n_chk = 0, n_err = 0, tcnt = 0;
  bit done = 0;

  vbus_path_ctrl i_vbus_path_ctrl (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .conn_state(conn_state),
    .vdd_uv_flag(vdd_uv_flag), .vdd_ov_flag(vdd_ov_flag), .vdd_uv_chk(vdd_uv_chk),
    .vdd_ov_chk(vdd_ov_chk), .sample_valid(sample_valid), .vbus_code(vbus_code),
    .target_code(target_code), .hi_trim(hi_trim), .lo_trim(lo_trim),
    .range_chk_en(range_chk_en), .vbus_uvlo_code(vbus_uvlo_code), .dischg_en(dischg_en),
    .xition_ms(xition_ms), .dischg_ms(dischg_ms), .path_en_n(path_en_n),
    .dischg_on(dischg_on), .err_req(err_req), .vbus_ok(vbus_ok), .blanking(blanking)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    #1;
    tcnt = tcnt + 1;
    ms_tick = (tcnt % 8 == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: percent window, two-strike filter, path states 0 off 1 on 2 recovery
  int m_hi = 0, m_lo = 0, m_tq = 0, m_bcnt = 0, m_dcnt = 0, m_st = 0;
  bit m_ok = 0, m_strike = 0, m_blow = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_tq = 0; m_bcnt = 0; m_dcnt = 0; m_st = 0;
      m_ok = 0; m_strike = 0; m_blow = 0;
    end else begin
      int tg, cd; bit chg, blank, good, att, vg; int nst;
      tg = int'(target_code); cd = int'(vbus_code);
      chg = (tg != m_tq);
      blank = (m_bcnt > 0);
      good = range_chk_en ? (cd >= m_lo && cd <= m_hi) : (cd > int'(vbus_uvlo_code));
      att = (conn_state != 0);
      vg = !((vdd_uv_chk && vdd_uv_flag) || (vdd_ov_chk && vdd_ov_flag));
      nst = m_st;
      if (m_st == 0 && att && vg && m_ok && !blank && !chg) nst = 1;
      else if (m_st == 1 && (!att || !m_ok)) begin
        nst = att ? 2 : 0;
        if (dischg_en) m_dcnt = int'(dischg_ms) + 1;
      end else if (m_st == 2 && !att) nst = 0;
      if (m_dcnt > 0 && (ms_tick || m_dcnt > int'(dischg_ms))) m_dcnt = m_dcnt - 1;
      if (!att) begin m_ok = 0; m_strike = 0; end
      else if (sample_valid && !blank && !chg) begin
        if (good) begin m_ok = 1; m_strike = 0; end
        else begin if (m_strike) m_ok = 0; m_strike = 1; end
      end
      if (chg) begin m_bcnt = int'(xition_ms); m_blow = dischg_en && (tg < m_tq); end
      else if (ms_tick && m_bcnt > 0) m_bcnt = m_bcnt - 1;
      m_st = nst;
      m_hi = tg * (105 + int'(hi_trim)) / 100;
      m_lo = tg * (95 - int'(lo_trim)) / 100;
      m_tq = tg;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 path_en_n vs model", int'(path_en_n), (m_st != 1) ? 1 : 0);
      chk("R7 dischg_on vs model", int'(dischg_on), (m_dcnt > 0 || (m_bcnt > 0 && m_blow)) ? 1 : 0);
      chk("R8 err_req vs model", int'(err_req), (m_st == 2) ? 1 : 0);
      chk("R4 vbus_ok vs model", int'(vbus_ok), int'(m_ok));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    step(3);
    chk("R1 path_en_n at reset", int'(path_en_n), 1);
    chk("R1 dischg_on at reset", int'(dischg_on), 0);
    chk("R1 err_req at reset", int'(err_req), 0);
    chk("R1 vbus_ok at reset", int'(vbus_ok), 0);
    rst_n = 1'b1;
    target_code = 10'd500; sample_valid = 1'b1; vbus_code = 10'd500;
    step(40);
    // R5: undervoltage on VDD blocks closing
    vdd_uv_chk = 1'b1; vdd_uv_flag = 1'b1; conn_state = 2'd1;
    step(6);
    chk("R5 blocked by vdd uv", int'(path_en_n), 1);
    vdd_uv_flag = 1'b0;
    step(3);
    chk("R5 closes when qualified", int'(path_en_n), 0);
    // R6: VDD overvoltage after closing is ignored
    vdd_ov_chk = 1'b1; vdd_ov_flag = 1'b1;
    step(5);
    chk("R6 vdd ov ignored", int'(path_en_n), 0);
    // R2: both window limits of 500 with trim 5 (450..550)
    vbus_code = 10'd550; step(5);
    chk("R2 upper limit inside", int'(path_en_n), 0);
    vbus_code = 10'd450; step(5);
    chk("R2 lower limit inside", int'(path_en_n), 0);
    // R4: a single bad sample does not trip
    vbus_code = 10'd449; step(1);
    vbus_code = 10'd500; step(4);
    chk("R4 single strike kept", int'(vbus_ok), 1);
    // R4: bad value without sample_valid is ignored
    sample_valid = 1'b0; vbus_code = 10'd900; step(5);
    chk("R4 invalid samples ignored", int'(path_en_n), 0);
    vbus_code = 10'd500; sample_valid = 1'b1; step(2);
    // R3: window off, only undervoltage code matters
    range_chk_en = 1'b0; vbus_code = 10'd700; step(5);
    chk("R3 above uvlo passes", int'(path_en_n), 0);
    range_chk_en = 1'b1; vbus_code = 10'd500; step(2);
    // R9 and R10: lower target blanks and discharges
    target_code = 10'd450; vbus_code = 10'd800; step(3);
    chk("R10 discharge on lower target", int'(dischg_on), 1);
    chk("R9 blanked fault ignored", int'(path_en_n), 0);
    vbus_code = 10'd450; step(40);
    chk("R10 discharge ends after blank", int'(dischg_on), 0);
    // R2 and R8: 496 is above 450*110/100=495
    vbus_code = 10'd496; step(5);
    chk("R2 one above upper trips", int'(path_en_n), 1);
    chk("R8 error requested", int'(err_req), 1);
    chk("R8 discharge on fault", int'(dischg_on), 1);
    conn_state = 2'd0; step(3);
    chk("R8 error cleared on detach", int'(err_req), 0);
    step(40);
    // R7: detach after close discharges for dischg_ms ticks
    vdd_ov_flag = 1'b0; vbus_code = 10'd450; conn_state = 2'd3; step(4);
    chk("R5 debug accessory closes", int'(path_en_n), 0);
    conn_state = 2'd0; step(2);
    chk("R7 released on detach", int'(path_en_n), 1);
    chk("R7 discharge after detach", int'(dischg_on), 1);
    step(40);
    chk("R7 discharge timed out", int'(dischg_on), 0);
    // R11: discharge disabled
    dischg_en = 1'b0; conn_state = 2'd1; step(4);
    conn_state = 2'd0; step(2);
    chk("R11 no discharge on detach", int'(dischg_on), 0);
    target_code = 10'd400; step(3);
    chk("R11 no discharge on lower target", int'(dischg_on), 0);
    step(40);
    // R3: window off, below undervoltage code trips
    dischg_en = 1'b1; vbus_code = 10'd400; conn_state = 2'd2; step(4);
    chk("R5 unoriented debug closes", int'(path_en_n), 0);
    range_chk_en = 1'b0; vbus_code = 10'd150; step(5);
    chk("R3 below uvlo trips", int'(err_req), 1);
    conn_state = 2'd0; step(10);
    finish_run();
  end
endmodule